// File: doc/BRIEF.md
# SPI Pause and Low-Power Controller

This controller sits beside the command engine of an SPI slave and decides when that engine may advance, when the serial output may drive, and when the slave is asleep. It runs on a free-running system clock. Chip select, serial clock and the pause pin are first passed through a synchroniser of `SYNC_STAGES` flops. Edges are then found by comparing each synchronised level with its value one clock earlier. The command engine supplies a one-clock `sleep_req` pulse when it has just decoded the sleep opcode.

The pause (hold) machine has three states: `HS_IDLE`, `HS_HELD_LO` and `HS_HELD_HI`. It enters a held state while chip select and the pause pin are both low, and the state it picks records the serial clock level at entry. It returns to `HS_IDLE` in two cases: the pause pin is high and the serial clock is back at the recorded level, or chip select rises, which aborts the running command. The sleep machine has four states: `SL_AWAKE`, `SL_ARMED`, `SL_ASLEEP` and `SL_WAKING`. `SL_AWAKE` goes to `SL_ARMED` on `sleep_req`. `SL_ARMED` goes to `SL_ASLEEP` on a chip-select rise. It falls back to `SL_AWAKE` on a serial-clock rise, or on a chip-select rise while held. `SL_ASLEEP` goes to `SL_WAKING` on a chip-select fall. `SL_WAKING` goes to `SL_AWAKE` after `WAKE_CYCLES` clocks.

Top module: `spi_pause_sleep_ctrl`

## Requirements
- R1: After reset, `eng_freeze`=0, `so_en`=0, `asleep`=0, `ready`=1, `cmd_abort`=0 and `wake_err`=0.
- R2: Each pin acts through `SYNC_STAGES` flops plus one state flop. While the synchronised chip select is low, the synchronised pause pin is low and `ready`=1, the controller enters hold: `eng_freeze`=1 and `so_en`=0. Hold records the synchronised serial clock level at entry.
- R3: Hold is left only when the pause pin is high and the serial clock equals the level recorded at entry. A pause release made at the other clock level keeps hold until the serial clock returns to the recorded level.
- R4: `so_en`=1 exactly when chip select is low, hold is inactive and `ready`=1.
- R5: A chip-select high seen while held gives a one-clock `cmd_abort` pulse and ends hold. If the sleep machine is armed at that moment, it returns to awake and does not sleep.
- R6: After `sleep_req`, the first chip-select rise with no serial-clock rise between them puts the controller to sleep: `asleep`=1, `ready`=0, `eng_freeze`=1.
- R7: A serial-clock rise outside hold, after `sleep_req` and before the chip-select rise, cancels the sleep request, so `asleep` stays 0.
- R8: A chip-select fall while asleep clears `asleep` and starts wake-up. `ready` stays 0, `eng_freeze`=1 and `so_en`=0 for exactly `WAKE_CYCLES` clocks, then `ready` returns to 1.
- R9: A chip-select fall during wake-up gives a one-clock `wake_err` pulse and does not restart the wake-up count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, asynchronous |
| hold_n | input | 1 | Pause pin, active low, asynchronous |
| sleep_req | input | 1 | One-clock pulse: sleep opcode decoded |
| eng_freeze | output | 1 | Stop the command shifter (hold, asleep or waking) |
| so_en | output | 1 | Serial output driver enable |
| asleep | output | 1 | Sleep state active |
| ready | output | 1 | Low while asleep or waking |
| cmd_abort | output | 1 | Pulse: command aborted by chip-select rise during hold |
| wake_err | output | 1 | Pulse: chip-select fall during wake-up |

## Verification
A hold machine stuck in the wrong held state would leave `eng_freeze` high after a correct release, or drop it at the wrong clock level. That shows on the clock right after the synchronised pins change. A sleep machine in the wrong state shows at once on `asleep` or `ready`. A wake-up count that restarts or runs short or long moves the rise of `ready` by at least one clock. The bench model runs the same pin sequence through its own delay line and compares all six outputs on every clock, so each of these errors is reported within one clock.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;
    localparam int PIN_CS   = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_HOLD = 2;
    localparam int NUM_PINS = 3;
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b101;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_HELD_LO,
        HS_HELD_HI
    } hold_st_t;

    typedef enum logic [1:0] {
        SL_AWAKE,
        SL_ARMED,
        SL_ASLEEP,
        SL_WAKING
    } sleep_st_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else if (STAGES == 1) chain_q <= pin_i[b];
            else chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
        end
        assign lvl_o[b] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else prev_q <= lvl_o;
    end

    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import spi_pause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_lvl,
    input  logic sck_lvl,
    input  logic hold_lvl,
    input  logic enable,
    output logic held,
    output logic abort
);
    hold_st_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:
                if (!cs_lvl && !hold_lvl && enable)
                    state_d = sck_lvl ? HS_HELD_HI : HS_HELD_LO;
            HS_HELD_LO:
                if (cs_lvl || (hold_lvl && !sck_lvl)) state_d = HS_IDLE;
            HS_HELD_HI:
                if (cs_lvl || (hold_lvl && sck_lvl)) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else state_q <= state_d;
    end

    always_comb begin
        held  = (state_q != HS_IDLE);
        abort = held && cs_lvl;
    end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import spi_pause_pkg::*;
#(
    parameter int WAKE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic sck_rise,
    input  logic held,
    output logic ready,
    output logic asleep,
    output logic wake_err
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

    sleep_st_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SL_AWAKE:
                if (sleep_req) state_d = SL_ARMED;
            SL_ARMED:
                if (cs_rise) state_d = held ? SL_AWAKE : SL_ASLEEP;
                else if (sck_rise && !held) state_d = SL_AWAKE;
            SL_ASLEEP:
                if (cs_fall) begin
                    state_d = SL_WAKING;
                    cnt_d   = '0;
                end
            SL_WAKING:
                if (cnt_q == CNT_LAST) state_d = SL_AWAKE;
                else cnt_d = cnt_q + 1'b1;
            default: state_d = SL_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SL_AWAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        asleep   = (state_q == SL_ASLEEP);
        ready    = (state_q == SL_AWAKE) || (state_q == SL_ARMED);
        wake_err = (state_q == SL_WAKING) && cs_fall;
    end
endmodule

// File: rtl/spi_pause_sleep_ctrl.sv
module spi_pause_sleep_ctrl
    import spi_pause_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic sleep_req,
    output logic eng_freeze,
    output logic so_en,
    output logic asleep,
    output logic ready,
    output logic cmd_abort,
    output logic wake_err
);
    logic [NUM_PINS-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
    logic held;

    assign pin_raw[PIN_CS]   = cs_n;
    assign pin_raw[PIN_SCK]  = sck;
    assign pin_raw[PIN_HOLD] = hold_n;

    pin_sync #(
        .WIDTH(NUM_PINS),
        .STAGES(SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_raw),
        .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    hold_fsm u_hold (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(pin_lvl[PIN_CS]), .sck_lvl(pin_lvl[PIN_SCK]),
        .hold_lvl(pin_lvl[PIN_HOLD]), .enable(ready),
        .held(held), .abort(cmd_abort)
    );

    sleep_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_sleep (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cs_rise(pin_rise[PIN_CS]), .cs_fall(pin_fall[PIN_CS]),
        .sck_rise(pin_rise[PIN_SCK]), .held(held),
        .ready(ready), .asleep(asleep), .wake_err(wake_err)
    );

    assign eng_freeze = held || !ready;
    assign so_en      = !pin_lvl[PIN_CS] && !held && ready;
endmodule

// File: rtl/spi_pause_sleep_chk.sv
module spi_pause_sleep_chk (
    input logic clk,
    input logic rst_n,
    input logic held,
    input logic eng_freeze,
    input logic so_en,
    input logic asleep,
    input logic ready,
    input logic cmd_abort,
    input logic wake_err
);
    assert_oe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> (!held && ready && !eng_freeze));

    assert_notready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (eng_freeze && !so_en));

    assert_abort_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> !held);

    assert_abort_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> !cmd_abort);

    assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> asleep);

    assert_sleep_to_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> !ready);

    assert_err_in_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |-> (!ready && !asleep));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |=> !wake_err);
endmodule

bind spi_pause_sleep_ctrl spi_pause_sleep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .held(held), .eng_freeze(eng_freeze),
    .so_en(so_en), .asleep(asleep), .ready(ready),
    .cmd_abort(cmd_abort), .wake_err(wake_err)
);

// File: tb/spi_pause_sleep_ctrl_test.sv
module spi_pause_sleep_ctrl_test;
    localparam int SYNC_STAGES = 2;
    localparam int WAKE_CYCLES = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, sleep_req = 1'b0;
    logic eng_freeze, so_en, asleep, ready, cmd_abort, wake_err;

    int checks = 0;
    int errors = 0;
    int err_pulses = 0;
    int abort_pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_pause_sleep_ctrl #(.SYNC_STAGES(SYNC_STAGES), .WAKE_CYCLES(WAKE_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sleep_req(sleep_req), .eng_freeze(eng_freeze), .so_en(so_en),
        .asleep(asleep), .ready(ready), .cmd_abort(cmd_abort), .wake_err(wake_err)
    );

    // Behavioural reference: delay lines per pin, integer modes, a countdown.
    bit dl_cs[$], dl_sck[$], dl_hold[$];
    bit old_cs, old_sck;
    int hmode;     // 0 free, 1 paused at sck low, 2 paused at sck high
    int smode;     // 0 awake, 1 armed, 2 asleep, 3 waking
    int remaining;

    function automatic void model_reset();
        dl_cs = {}; dl_sck = {}; dl_hold = {};
        for (int i = 0; i < SYNC_STAGES; i++) begin
            dl_cs.push_back(1'b1); dl_sck.push_back(1'b0); dl_hold.push_back(1'b1);
        end
        old_cs = 1'b1; old_sck = 1'b0;
        hmode = 0; smode = 0; remaining = 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else begin
            bit c, s, h, csr, csf, skr, rdy, paused;
            c = dl_cs[0]; s = dl_sck[0]; h = dl_hold[0];
            csr = c && !old_cs; csf = !c && old_cs; skr = s && !old_sck;
            rdy = (smode < 2); paused = (hmode != 0);
            case (smode)
                0: if (sleep_req) smode = 1;
                1: if (csr) smode = paused ? 0 : 2;
                   else if (skr && !paused) smode = 0;
                2: if (csf) begin smode = 3; remaining = WAKE_CYCLES; end
                3: begin remaining--; if (remaining == 0) smode = 0; end
                default: smode = 0;
            endcase
            if (hmode == 0) begin
                if (!c && !h && rdy) hmode = s ? 2 : 1;
            end else if (c || (h && (s == (hmode == 2)))) hmode = 0;
            old_cs = c; old_sck = s;
            void'(dl_cs.pop_front()); void'(dl_sck.pop_front()); void'(dl_hold.pop_front());
            dl_cs.push_back(cs_n); dl_sck.push_back(sck); dl_hold.push_back(hold_n);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit c, rdy, paused;
            c = dl_cs[0];
            rdy = (smode < 2); paused = (hmode != 0);
            check("R2 eng_freeze", eng_freeze, paused || !rdy);
            check("R4 so_en", so_en, !c && !paused && rdy);
            check("R6 asleep", asleep, smode == 2);
            check("R8 ready", ready, rdy);
            check("R5 cmd_abort", cmd_abort, paused && c);
            check("R9 wake_err", wake_err, (smode == 3) && !c && old_cs);
            if (cmd_abort) abort_pulses++;
            if (wake_err) err_pulses++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulse();
        sck = 1'b1; step(4); sck = 1'b0; step(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lowcnt;
        step(3);
        // R1: reset state
        check("R1 eng_freeze", eng_freeze, 1'b0);
        check("R1 so_en", so_en, 1'b0);
        check("R1 asleep", asleep, 1'b0);
        check("R1 ready", ready, 1'b1);
        check("R1 cmd_abort", cmd_abort, 1'b0);
        check("R1 wake_err", wake_err, 1'b0);
        rst_n = 1'b1;
        step(2);

        // R4: selected and clocking
        cs_n = 1'b0; step(5);
        check("R4 so_en select", so_en, 1'b1);
        sck_pulse(); sck_pulse();

        // R2/R3: pause at sck low, release attempted at sck high
        hold_n = 1'b0; step(5);
        check("R2 held low", eng_freeze, 1'b1);
        sck = 1'b1; step(3); hold_n = 1'b1; step(5);
        check("R3 stays held", eng_freeze, 1'b1);
        sck = 1'b0; step(5);
        check("R3 released", eng_freeze, 1'b0);

        // R2/R3: pause at sck high
        sck = 1'b1; step(4); hold_n = 1'b0; step(4);
        sck = 1'b0; step(3); hold_n = 1'b1; step(5);
        check("R3 held high", eng_freeze, 1'b1);
        sck = 1'b1; step(5);
        check("R3 released high", eng_freeze, 1'b0);
        sck = 1'b0; step(4);

        // R5: chip select rises during pause
        hold_n = 1'b0; step(5);
        cs_n = 1'b1; step(6);
        check("R5 abort seen", abort_pulses == 1, 1'b1);
        check("R5 freed", eng_freeze, 1'b0);
        hold_n = 1'b1; step(4);

        // R7: sleep request cancelled by a clock
        cs_n = 1'b0; step(4);
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        sck_pulse();
        cs_n = 1'b1; step(6);
        check("R7 cancelled", asleep, 1'b0);

        // R5: armed then abort via hold
        cs_n = 1'b0; step(4);
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        hold_n = 1'b0; step(4);
        cs_n = 1'b1; step(6);
        check("R5 no sleep", asleep, 1'b0);
        hold_n = 1'b1; step(4);

        // R6: sleep entry
        cs_n = 1'b0; step(4);
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        step(3); cs_n = 1'b1; step(6);
        check("R6 asleep", asleep, 1'b1);
        check("R6 not ready", ready, 1'b0);
        sck_pulse(); hold_n = 1'b0; step(3); hold_n = 1'b1;
        check("R6 still asleep", asleep, 1'b1);

        // R8: wake timing
        cs_n = 1'b0; lowcnt = 0;
        step(SYNC_STAGES + 1);
        check("R8 left sleep", asleep, 1'b0);
        while (!ready && lowcnt < 1000) begin lowcnt++; step(1); end
        check("R8 wake length", lowcnt == WAKE_CYCLES, 1'b1);
        if (lowcnt != WAKE_CYCLES) $display("FAIL R8: actual %0d expected %0d", lowcnt, WAKE_CYCLES);

        // R9: chip select falls during wake-up
        cs_n = 1'b0; step(2);
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        step(2); cs_n = 1'b1; step(6);
        cs_n = 1'b0; step(5);
        cs_n = 1'b1; step(4);
        cs_n = 1'b0; lowcnt = 0;
        while (!ready && lowcnt < 1000) begin lowcnt++; step(1); end
        check("R9 err pulse", err_pulses == 1, 1'b1);
        check("R9 no restart", lowcnt < WAKE_CYCLES, 1'b1);
        step(5);
        check("R9 awake", ready, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule